// File: doc/BRIEF.md
# Sleep Clock-Gating Sequencer

This block decides when a group of clocks may be switched off after the chip asks to sleep. Software first loads three values through a small register port: a delay count, a delay-enable bit and a per-clock disable mask. When `sleep_req` goes high, the sequencer captures these values and waits. It then asserts one `gate_off` line for each clock that the mask selects. The gating cells further down the clock tree act on these lines.

The wait can end in two ways. When the delay-enable bit is set, the sequencer counts a fixed number of cycles and ignores the acknowledge inputs. When the bit is clear, the sequencer waits until every selected clock domain raises its acknowledge input. In that case a non-zero delay acts as a timeout on the acknowledges, and a zero delay means there is no timeout. Dropping `sleep_req` cancels the sequence at any point and releases every clock at once.

Top module: `sleep_gate_seq`

## Requirements
- R1: After reset, the delay register (address 0), the mask register (address 1) and the control register (address 2) all read zero, and `gate_off` is zero.
- R2: A write stores all 64 bits at address 0 and at address 1, and a read returns them unchanged, including unused bits. Only bits 23:0 of address 0 form the delay, and only bits 33:0 of address 1 form the mask. At address 2, only bit 0 (delay-enable) is stored; the other bits read zero. Address 3 reads zero.
- R3: With delay-enable at 1 and delay D, `gate_off` equals mask[33:0] from the D-th rising edge after the edge that first samples `sleep_req` high. When D is 0, `gate_off` equals the mask in the cycle right after that sampling edge.
- R4: In fixed-delay mode, `gate_off` stays zero during the wait even when all `clk_ack` bits are high.
- R5: With delay-enable at 0, `gate_off` becomes the mask one cycle after the first edge, later than the sampling edge, at which `clk_ack[i]` is high for every bit i that is set in the mask. Acknowledge bits of unmasked clocks have no effect.
- R6: With delay-enable at 0 and a non-zero delay D, the clocks are gated at the D-th edge after the sampling edge even if the acknowledges are incomplete.
- R7: With delay-enable at 0 and D equal to 0, the sequencer waits without limit while the acknowledges are incomplete, and `gate_off` stays zero.
- R8: When `sleep_req` is low, `gate_off` is zero in that same cycle. A later request starts a fresh count.
- R9: Once gated, `gate_off` holds its value while `sleep_req` stays high, whatever `clk_ack` does.
- R10: Register writes made during an active sequence change neither its timing nor its mask. The new values apply to the next request.
- R11: A `gate_off` bit whose mask bit is 0 is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 delay, 1 mask, 2 control |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from `reg_addr` |
| sleep_req | input | 1 | Sleep request, held high for the whole sequence |
| clk_ack | input | 34 | Per-clock ready-to-stop acknowledges |
| gate_off | output | 34 | Per-clock gate-off commands |

## Verification
The assertions assume that `sleep_req` is a level held high until software or the power controller withdraws it. They also assume that `clk_ack` is synchronous to `clk`. The bench drives every input on the falling edge, so the design samples a settled level. The bench never pulses `sleep_req` for less than a full cycle. The bench changes the acknowledges only at cycle boundaries, so each expected gating edge can be counted exactly from the edge that accepts the request.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_GATED = 2'd2
  } seq_state_e;

  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] A_DELAY = 2'd0;
  localparam logic [REG_ADDR_W-1:0] A_MASK  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] A_CTRL  = 2'd2;
endpackage

// File: rtl/sgs_regfile.sv
module sgs_regfile
  import sgs_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DLY_W  = 24,
  parameter int NCLK   = 34
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic [DLY_W-1:0]      dly_val,
  output logic [NCLK-1:0]       mask_val,
  output logic                  dly_en
);
  logic [DATA_W-1:0] dly_q, mask_q;
  logic              en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_DELAY: dly_q  <= wdata;
        A_MASK:  mask_q <= wdata;
        A_CTRL:  en_q   <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_DELAY: rdata = dly_q;
      A_MASK:  rdata = mask_q;
      A_CTRL:  rdata = {{(DATA_W-1){1'b0}}, en_q};
      default: rdata = '0;
    endcase
  end

  assign dly_val  = dly_q[DLY_W-1:0];
  assign mask_val = mask_q[NCLK-1:0];
  assign dly_en   = en_q;

  // R2: a delay write is visible on the next cycle with all bits kept
  assert_delay_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DELAY) |=> (dly_q == $past(wdata)));
endmodule

// File: rtl/sgs_ack_merge.sv
module sgs_ack_merge #(
  parameter int NCLK = 34
) (
  input  logic [NCLK-1:0] ack,
  input  logic [NCLK-1:0] mask,
  output logic            all_ok
);
  logic [NCLK-1:0] sat;

  for (genvar i = 0; i < NCLK; i++) begin : g_sat
    assign sat[i] = ack[i] | ~mask[i];
  end

  assign all_ok = &sat;
endmodule

// File: rtl/sgs_sequencer.sv
module sgs_sequencer
  import sgs_pkg::*;
#(
  parameter int DLY_W = 24,
  parameter int NCLK  = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [NCLK-1:0]  clk_ack,
  input  logic [DLY_W-1:0] dly_val,
  input  logic [NCLK-1:0]  mask_val,
  input  logic             dly_en,
  output logic [NCLK-1:0]  gate_q
);
  seq_state_e       state_q;
  logic [DLY_W-1:0] cnt_q, dly_s, cnt_inc;
  logic [NCLK-1:0]  mask_s;
  logic             en_s, all_ok, hit_dly, finish;

  sgs_ack_merge #(.NCLK(NCLK)) u_ack (
    .ack   (clk_ack),
    .mask  (mask_s),
    .all_ok(all_ok)
  );

  assign cnt_inc = cnt_q + DLY_W'(1);
  assign hit_dly = (dly_s != '0) && (cnt_inc == dly_s);
  assign finish  = en_s ? hit_dly : (all_ok || hit_dly);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dly_s   <= '0;
      mask_s  <= '0;
      en_s    <= 1'b0;
      gate_q  <= '0;
    end else if (!sleep_req) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      gate_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          dly_s  <= dly_val;
          mask_s <= mask_val;
          en_s   <= dly_en;
          cnt_q  <= '0;
          if (dly_en && dly_val == '0) begin
            state_q <= ST_GATED;
            gate_q  <= mask_val;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (dly_s != '0) cnt_q <= cnt_inc;
          if (finish) begin
            state_q <= ST_GATED;
            gate_q  <= mask_s;
          end
        end
        default: ;
      endcase
    end
  end

  // R11: only captured-mask clocks can be commanded off
  assert_in_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q & ~mask_s) == '0);

  // R4: fixed mode stays ungated until the count is reached, acks notwithstanding
  assert_fixed_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && en_s && sleep_req && !hit_dly) |=> gate_q == '0);

  // R7: no timeout when delay is zero in acknowledge mode
  assert_no_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !en_s && dly_s == '0 && !all_ok && sleep_req)
      |=> gate_q == '0);

  // R9: gated outputs hold while the request stays
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GATED && sleep_req) |=> $stable(gate_q));

  // R10: captured settings do not move during a sequence
  assert_snapshot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && sleep_req) |=>
      ($stable(dly_s) && $stable(mask_s) && $stable(en_s)));

  // R8: a withdrawn request clears count and gating
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_req |=> (cnt_q == '0 && gate_q == '0));
endmodule

// File: rtl/sleep_gate_seq.sv
module sleep_gate_seq
  import sgs_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DLY_W  = 24,
  parameter int NCLK   = 34
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_en,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic                  sleep_req,
  input  logic [NCLK-1:0]       clk_ack,
  output logic [NCLK-1:0]       gate_off
);
  logic [DLY_W-1:0] dly_val;
  logic [NCLK-1:0]  mask_val, gate_q;
  logic             dly_en;

  sgs_regfile #(.DATA_W(DATA_W), .DLY_W(DLY_W), .NCLK(NCLK)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .dly_val (dly_val),
    .mask_val(mask_val),
    .dly_en  (dly_en)
  );

  sgs_sequencer #(.DLY_W(DLY_W), .NCLK(NCLK)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_req(sleep_req),
    .clk_ack  (clk_ack),
    .dly_val  (dly_val),
    .mask_val (mask_val),
    .dly_en   (dly_en),
    .gate_q   (gate_q)
  );

  // R8: release is immediate when the request drops
  assign gate_off = gate_q & {NCLK{sleep_req}};
endmodule

// File: tb/sim_sleep_gate_seq.sv
module sim_sleep_gate_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        sleep_req = 1'b0;
  logic [33:0] clk_ack = '0;
  logic [33:0] gate_off;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sleep_gate_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
    .clk_ack(clk_ack), .gate_off(gate_off)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rreg(input string req, input logic [1:0] a, input logic [63:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic setup(input logic en, input logic [63:0] dly, input logic [63:0] msk);
    wreg(2'd0, dly);
    wreg(2'd1, msk);
    wreg(2'd2, {63'd0, en});
  endtask

  task automatic drop_req(input string req);
    sleep_req = 1'b0;
    #1;
    chk(req, {30'd0, gate_off}, 64'd0);
    @(negedge clk);
  endtask

  // wait d cycles expecting zero, then expect the mask
  task automatic expect_gate(input string req, input int d, input logic [33:0] m);
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      chk(req, {30'd0, gate_off}, 64'd0);
    end
    @(negedge clk);
    chk(req, {30'd0, gate_off}, {30'd0, m});
  endtask

  task automatic t_reset;
    rreg("R1 delay", 2'd0, 64'd0);
    rreg("R1 mask", 2'd1, 64'd0);
    rreg("R1 ctrl", 2'd2, 64'd0);
    chk("R1 gate", {30'd0, gate_off}, 64'd0);
  endtask

  task automatic t_regs;
    wreg(2'd0, 64'hDEAD_BEEF_0012_3456);
    rreg("R2 delay", 2'd0, 64'hDEAD_BEEF_0012_3456);
    wreg(2'd1, 64'hFFFF_FFFC_0000_0F0F);
    rreg("R2 mask", 2'd1, 64'hFFFF_FFFC_0000_0F0F);
    wreg(2'd2, 64'hFF);
    rreg("R2 ctrl", 2'd2, 64'd1);
    rreg("R2 addr3", 2'd3, 64'd0);
  endtask

  task automatic t_fixed;
    setup(1'b1, 64'd5, 64'h3_0000_00A5);
    sleep_req = 1'b1;
    clk_ack = '1;  // R4: acks must be ignored
    expect_gate("R3/R4 fixed", 5, 34'h3_0000_00A5);
    chk("R11 unmasked", {30'd0, gate_off & ~34'h3_0000_00A5}, 64'd0);
    for (int i = 0; i < 6; i++) begin
      clk_ack = (i % 2 == 0) ? '0 : 34'h2_AAAA_5555;
      @(negedge clk);
      chk("R9 hold", {30'd0, gate_off}, 64'h3_0000_00A5);
    end
    drop_req("R8 release");
    clk_ack = '0;
  endtask

  task automatic t_fixed_zero;
    setup(1'b1, 64'hFFFF_FF00_0000_0000, 64'hFFFF_FFFC_0000_0F0F);
    sleep_req = 1'b1;
    expect_gate("R3 zero delay", 0, 34'h0_0000_0F0F);
    drop_req("R8 release zero");
  endtask

  task automatic t_ack;
    setup(1'b0, 64'd0, 64'h1_0000_0011);
    sleep_req = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R7 wait forever", {30'd0, gate_off}, 64'd0);
    end
    clk_ack = 34'h0_FFFF_FF11;  // masked bit 32 still low
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 partial ack", {30'd0, gate_off}, 64'd0);
    end
    clk_ack = 34'h1_0000_0011;
    @(negedge clk);
    chk("R5 ack gate", {30'd0, gate_off}, 64'h1_0000_0011);
    drop_req("R8 release ack");
    clk_ack = '0;
  endtask

  task automatic t_timeout;
    setup(1'b0, 64'd7, 64'h0_F000_000F);
    sleep_req = 1'b1;
    clk_ack = 34'h0_F000_0000;
    expect_gate("R6 timeout", 7, 34'h0_F000_000F);
    drop_req("R8 release timeout");
    clk_ack = '0;
  endtask

  task automatic t_snapshot;
    setup(1'b1, 64'd6, 64'h0_0000_3C3C);
    sleep_req = 1'b1;
    @(negedge clk);
    chk("R10 start", {30'd0, gate_off}, 64'd0);
    wreg(2'd0, 64'd2);
    wreg(2'd1, 64'h2_0000_0000);
    chk("R10 mid", {30'd0, gate_off}, 64'd0);
    @(negedge clk);
    chk("R10 mid", {30'd0, gate_off}, 64'd0);
    @(negedge clk);
    chk("R10 old values", {30'd0, gate_off}, 64'h0_0000_3C3C);
    drop_req("R8 release snap");
    sleep_req = 1'b1;
    expect_gate("R10 new values", 2, 34'h2_0000_0000);
    drop_req("R8 release snap2");
  endtask

  task automatic t_restart;
    setup(1'b1, 64'd4, 64'h0_0000_0001);
    sleep_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    drop_req("R8 early drop");
    sleep_req = 1'b1;
    expect_gate("R8 fresh count", 4, 34'h0_0000_0001);
    drop_req("R8 release restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_fixed;
    t_fixed_zero;
    t_ack;
    t_timeout;
    t_snapshot;
    t_restart;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule